// File: doc/BRIEF.md
# Character-Unit Raster Timing Generator

This block produces the raster timing for a display pipe from a small set of packed timing words. Software writes four timing words and one control word through a plain register-write port. Every write is accepted in the cycle it is presented, and the port has no back-pressure. The block counts pixels and lines on the pixel clock. From those counts it drives horizontal and vertical sync, a display-enable strobe, per-axis blanking and an interlace field flag.

Horizontal quantities are programmed in characters of eight pixels. Vertical quantities are programmed in lines. Totals, display extents and sync starts are stored as the value minus one. Each sync word carries a 5-bit pulse width and a bit that selects active-low polarity. Timing words are held in a pending copy and move into the working copy only on the last pixel of a frame, so a frame is never scanned with mixed timing. The control word takes effect on the next clock.

Top module: `crtc_timing_gen`

## Requirements
- R1: After reset all timing words and the control word read as zero. The outputs are then pix_x=0, line_y=0, de_o=0, hsync_o=0, vsync_o=0, hblank_o=1, vblank_o=1 and field_o=0.
- R2: Address 0 holds the horizontal word. Bits [HCHAR_W-1:0] are the total characters minus one, and bits [16+HCHAR_W-1:16] are the displayed characters minus one. While running, pix_x advances by one per clock through (total chars)×8 values and then wraps to 0.
- R3: Address 2 holds the vertical word. Bits [VLINE_W-1:0] are the total lines minus one, and bits [16+VLINE_W-1:16] are the displayed lines minus one. line_y advances when pix_x wraps, and wraps to 0 after the last line.
- R4: Address 1 holds the horizontal sync word. Bits [HCHAR_W-1:0] are the start character minus one, bits [20:16] are the width in characters and bit 21 is the active-low select. Sync is active for every pixel of characters start … start+width−1, so a pulse lasts width×8 clocks and repeats once per line.
- R5: Address 3 holds the vertical sync word. Its layout matches address 1, in lines: bits [VLINE_W-1:0] are the start line minus one, [20:16] are the width in lines and bit 21 is active-low. The pulse lasts width full lines and repeats once per frame.
- R6: A sync width of zero produces no pulse on that axis.
- R7: A polarity bit of 1 inverts the sync pin, so the pin rests high and pulses low.
- R8: de_o is high only inside both display extents. hblank_o is high past the displayed characters, and vblank_o is high past the displayed lines.
- R9: Control address 4, bit 2 is display-on. While it is 0, de_o=0, both blanks are 1 and each sync pin sits at its inactive level. Counting continues.
- R10: Control bit 3 is run. While it is 0, pix_x and line_y stay at 0 and the pending timing words pass straight to the working copy.
- R11: Control bit 1 is composite sync. While it is set, the hsync pin carries (horizontal XOR vertical active sync), XORed with the horizontal polarity bit.
- R12: Control bit 0 is interlace. While it is set, field_o toggles at the end of each frame. While it is clear, field_o is 0.
- R13: A timing word written before the last pixel of a frame takes effect at pixel 0 of the next frame. A write that lands on that last pixel takes effect one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0..4) |
| cfg_wdata | input | 32 | Register write data |
| pix_x | output | HCHAR_W+3 | Pixel position in the line |
| line_y | output | VLINE_W | Line position in the frame |
| hsync_o | output | 1 | Horizontal or composite sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Display-enable strobe |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| field_o | output | 1 | Interlace field flag |

## Verification
A timing-word write can land in the same cycle as the end-of-frame transfer from the pending copy to the working copy. The bench provokes this by waiting for the pixel just before the frame's last one and issuing a sync-width write so that its strobe is sampled on the final pixel. It then measures the hsync pulse of the next frame, which must keep the old width, and of the frame after, which must show the new width. A behavioural reference model compared on every clock independently confirms that the transfer and the write do not disturb each other.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  localparam int FIELD_HI_LSB = 16;
  localparam int SYNC_WID_W   = 5;
  localparam int SYNC_NEG_BIT = 21;

  localparam int CTL_INTERLACE = 0;
  localparam int CTL_COMPOSITE = 1;
  localparam int CTL_DISP_ON   = 2;
  localparam int CTL_RUN       = 3;
  localparam int CTL_W         = 4;

  typedef enum logic [2:0] {
    A_HORZ  = 3'd0,
    A_HSYNC = 3'd1,
    A_VERT  = 3'd2,
    A_VSYNC = 3'd3,
    A_CTRL  = 3'd4
  } crtc_addr_e;

  typedef struct packed {
    logic [15:0]           total_m1;
    logic [15:0]           disp_m1;
    logic [15:0]           start_m1;
    logic [SYNC_WID_W-1:0] width;
    logic                  neg;
  } axis_cfg_t;

  function automatic axis_cfg_t unpack_axis(input logic [31:0] extent_w,
                                            input logic [31:0] sync_w);
    axis_cfg_t c;
    c.total_m1 = extent_w[15:0];
    c.disp_m1  = extent_w[31:16];
    c.start_m1 = sync_w[15:0];
    c.width    = sync_w[FIELD_HI_LSB +: SYNC_WID_W];
    c.neg      = sync_w[SYNC_NEG_BIT];
    return c;
  endfunction

endpackage

// File: rtl/crtc_axis_cnt.sv
module crtc_axis_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  assign wrap = step && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (step)   cnt <= wrap ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/crtc_sync_win.sv
module crtc_sync_win #(
  parameter int W  = 8,
  parameter int WW = 5
) (
  input  logic [W-1:0]  pos,
  input  logic [W-1:0]  start_m1,
  input  logic [WW-1:0] width,
  output logic          act
);

  localparam int EW = W + WW + 1;

  logic [EW-1:0] first, past_end, here;

  always_comb begin
    here     = EW'(pos);
    first    = EW'(start_m1) + EW'(1);
    past_end = first + EW'(width);
    act      = (width != '0) && (here >= first) && (here < past_end);
  end

endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  input  logic        load_now,
  output axis_cfg_t   h_cfg,
  output axis_cfg_t   v_cfg,
  output logic [CTL_W-1:0] ctl
);

  localparam int NWORDS = 4;

  logic [31:0] pend [NWORDS];

  for (genvar i = 0; i < NWORDS; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n)                       pend[i] <= '0;
      else if (we && addr == 3'(i))     pend[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          ctl <= '0;
    else if (we && addr == A_CTRL)       ctl <= wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cfg <= '0;
      v_cfg <= '0;
    end else if (load_now) begin
      h_cfg <= unpack_axis(pend[A_HORZ], pend[A_HSYNC]);
      v_cfg <= unpack_axis(pend[A_VERT], pend[A_VSYNC]);
    end
  end

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int HCHAR_W  = 8,
  parameter int VLINE_W  = 11,
  parameter int CHAR_PIX = 8,
  localparam int SUB_W   = $clog2(CHAR_PIX),
  localparam int PIXW    = HCHAR_W + SUB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [PIXW-1:0]    pix_x,
  output logic [VLINE_W-1:0] line_y,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               hblank_o,
  output logic               vblank_o,
  output logic               field_o
);

  axis_cfg_t          h_cfg, v_cfg;
  logic [CTL_W-1:0]   ctl;
  logic               run, disp_on, composite, interlace;
  logic               load_now, frame_end;
  logic [SUB_W-1:0]   sub;
  logic [HCHAR_W-1:0] hchar;
  logic               sub_wrap, char_wrap;
  logic               h_act, v_act, h_past, v_past;

  assign run       = ctl[CTL_RUN];
  assign disp_on   = ctl[CTL_DISP_ON];
  assign composite = ctl[CTL_COMPOSITE];
  assign interlace = ctl[CTL_INTERLACE];
  assign load_now  = !run || frame_end;

  crtc_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .load_now (load_now),
    .h_cfg    (h_cfg),
    .v_cfg    (v_cfg),
    .ctl      (ctl)
  );

  // pixel within character, character within line, line within frame
  crtc_axis_cnt #(.W(SUB_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .clr(!run), .step(run),
    .limit(SUB_W'(CHAR_PIX - 1)), .cnt(sub), .wrap(sub_wrap)
  );

  crtc_axis_cnt #(.W(HCHAR_W)) u_char (
    .clk(clk), .rst_n(rst_n), .clr(!run), .step(sub_wrap),
    .limit(h_cfg.total_m1[HCHAR_W-1:0]), .cnt(hchar), .wrap(char_wrap)
  );

  crtc_axis_cnt #(.W(VLINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .clr(!run), .step(char_wrap),
    .limit(v_cfg.total_m1[VLINE_W-1:0]), .cnt(line_y), .wrap(frame_end)
  );

  assign pix_x = {hchar, sub};

  crtc_sync_win #(.W(HCHAR_W), .WW(SYNC_WID_W)) u_hwin (
    .pos(hchar), .start_m1(h_cfg.start_m1[HCHAR_W-1:0]),
    .width(h_cfg.width), .act(h_act)
  );

  crtc_sync_win #(.W(VLINE_W), .WW(SYNC_WID_W)) u_vwin (
    .pos(line_y), .start_m1(v_cfg.start_m1[VLINE_W-1:0]),
    .width(v_cfg.width), .act(v_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          field_o <= 1'b0;
    else if (!interlace) field_o <= 1'b0;
    else if (frame_end)  field_o <= ~field_o;
  end

  always_comb begin
    h_past   = hchar  > h_cfg.disp_m1[HCHAR_W-1:0];
    v_past   = line_y > v_cfg.disp_m1[VLINE_W-1:0];
    hblank_o = !disp_on || h_past;
    vblank_o = !disp_on || v_past;
    de_o     = disp_on && !h_past && !v_past;
    if (disp_on) begin
      hsync_o = (composite ? (h_act ^ v_act) : h_act) ^ h_cfg.neg;
      vsync_o = v_act ^ v_cfg.neg;
    end else begin
      hsync_o = h_cfg.neg;
      vsync_o = v_cfg.neg;
    end
  end

endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
  import crtc_pkg::*;
#(
  parameter int PIXW = 11,
  parameter int VW   = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            disp_on,
  input logic [PIXW-1:0] pix_x,
  input logic [VW-1:0]   line_y,
  input logic            de_o,
  input logic            hblank_o,
  input logic            vblank_o,
  input logic            hsync_o,
  input logic            vsync_o,
  input axis_cfg_t       h_cfg,
  input axis_cfg_t       v_cfg
);

  a_r10_hold_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pix_x == '0 && line_y == '0));

  a_r9_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (!de_o && hblank_o && vblank_o));

  a_r9_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (hsync_o == h_cfg.neg && vsync_o == v_cfg.neg));

  a_r8_de_not_blank: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (!hblank_o && !vblank_o));

  a_r2_pixel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && pix_x != '0) |-> (pix_x == PIXW'($past(pix_x) + 1'b1)));

  a_r13_no_midframe_load: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(pix_x == '0 && line_y == '0)) |-> ($stable(h_cfg) && $stable(v_cfg)));

endmodule

bind crtc_timing_gen crtc_timing_chk #(.PIXW(PIXW), .VW(VLINE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .disp_on  (disp_on),
  .pix_x    (pix_x),
  .line_y   (line_y),
  .de_o     (de_o),
  .hblank_o (hblank_o),
  .vblank_o (vblank_o),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .h_cfg    (h_cfg),
  .v_cfg    (v_cfg)
);

// File: tb/tb_crtc_timing_gen.sv
module tb_crtc_timing_gen;

  localparam int HW = 8;
  localparam int VW = 11;
  localparam int PW = HW + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wd = '0;
  logic [PW-1:0] pix_x;
  logic [VW-1:0] line_y;
  logic          hsync_o, vsync_o, de_o, hblank_o, vblank_o, field_o;

  always #5 clk = ~clk;

  crtc_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wd),
    .pix_x(pix_x), .line_y(line_y), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .hblank_o(hblank_o), .vblank_o(vblank_o), .field_o(field_o)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  bit  hneg = 0, vneg = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int unsigned p [4];
  int  m_ctl, m_x, m_y, m_field;
  int  a_ht, a_hd, a_hs, a_hw, a_hn, a_vt, a_vd, a_vs, a_vw, a_vn;
  bit  started = 0;

  function automatic void load_working();
    int hm = (1 << HW) - 1;
    int vm = (1 << VW) - 1;
    a_ht = p[0] & hm;          a_hd = (p[0] >> 16) & hm;
    a_hs = p[1] & hm;          a_hw = (p[1] >> 16) & 31;  a_hn = (p[1] >> 21) & 1;
    a_vt = p[2] & vm;          a_vd = (p[2] >> 16) & vm;
    a_vs = p[3] & vm;          a_vw = (p[3] >> 16) & 31;  a_vn = (p[3] >> 21) & 1;
  endfunction

  always @(posedge clk) begin
    int run, il, last, line_len;
    started = 1;
    if (!rst_n) begin
      foreach (p[i]) p[i] = 0;
      m_ctl = 0; m_x = 0; m_y = 0; m_field = 0;
      load_working();
    end else begin
      run = (m_ctl >> 3) & 1;
      il  = m_ctl & 1;
      last = 0;
      if (!run) begin
        m_x = 0; m_y = 0;
        load_working();
      end else begin
        line_len = (a_ht + 1) * 8;
        last = (m_x == line_len - 1) && (m_y == a_vt);
        if (m_x == line_len - 1) begin
          m_x = 0;
          m_y = (m_y == a_vt) ? 0 : m_y + 1;
        end else m_x++;
        if (last) load_working();
      end
      if (!il) m_field = 0;
      else if (last) m_field ^= 1;
      if (we) begin
        if (addr < 3'd4) p[addr] = wd;
        else if (addr == 3'd4) m_ctl = int'(wd & 32'hF);
      end
    end
  end

  always @(negedge clk) begin
    int on, cs, cx, ha, va, e_hs, e_vs;
    if (started && !finished) begin
      on = (m_ctl >> 2) & 1;
      cs = (m_ctl >> 1) & 1;
      cx = m_x / 8;
      ha = (a_hw != 0) && (cx >= a_hs + 1) && (cx < a_hs + 1 + a_hw);
      va = (a_vw != 0) && (m_y >= a_vs + 1) && (m_y < a_vs + 1 + a_vw);
      e_hs = on ? ((cs ? (ha ^ va) : ha) ^ a_hn) : a_hn;
      e_vs = on ? (va ^ a_vn) : a_vn;
      check("R2", "pix_x", pix_x, m_x);
      check("R3", "line_y", line_y, m_y);
      check("R4", "hsync_o", hsync_o, e_hs);
      check("R5", "vsync_o", vsync_o, e_vs);
      check("R8", "de_o", de_o, on && cx <= a_hd && m_y <= a_vd);
      check("R8", "hblank_o", hblank_o, !on || cx > a_hd);
      check("R8", "vblank_o", vblank_o, !on || m_y > a_vd);
      check("R12", "field_o", field_o, m_field);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] extent(input int tot_m1, input int disp_m1);
    return (32'(disp_m1) << 16) | 32'(tot_m1);
  endfunction

  function automatic logic [31:0] syncw(input int start_m1, input int width, input int neg);
    return (32'(neg) << 21) | (32'(width) << 16) | 32'(start_m1);
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_at(input int y, input int x);
    do @(negedge clk); while (!(line_y == VW'(y) && pix_x == PW'(x)));
  endtask

  task automatic wait_frame_start();
    wait_at(0, 0);
  endtask

  task automatic pulse(input bit vert, input bit neg, output int per, output int wid);
    bit a;
    do begin @(negedge clk); a = (vert ? vsync_o : hsync_o) ^ neg; end while (a);
    do begin @(negedge clk); a = (vert ? vsync_o : hsync_o) ^ neg; end while (!a);
    per = 0; wid = 0;
    while (a) begin wid++; per++; @(negedge clk); a = (vert ? vsync_o : hsync_o) ^ neg; end
    while (!a) begin per++; @(negedge clk); a = (vert ? vsync_o : hsync_o) ^ neg; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
    end
  end

  initial begin
    int per, wid, cnt, f0, px0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "pix_x", pix_x, 0);
    check("R1", "line_y", line_y, 0);
    check("R1", "de_o", de_o, 0);
    check("R1", "hsync_o", hsync_o, 0);
    check("R1", "vsync_o", vsync_o, 0);
    check("R1", "hblank_o", hblank_o, 1);
    check("R1", "vblank_o", vblank_o, 1);
    check("R1", "field_o", field_o, 0);
    rst_n = 1'b1;

    // 10 chars/line, 6 shown, sync at char 7 for 2; 12 lines, 8 shown, sync at line 9 for 2
    wr(0, extent(9, 5));
    wr(1, syncw(6, 2, 0));
    wr(2, extent(11, 7));
    wr(3, syncw(8, 2, 0));
    wr(4, 32'hC);

    pulse(0, 0, per, wid);
    check("R2", "hsync period", per, 80);
    check("R4", "hsync width", wid, 16);
    pulse(1, 0, per, wid);
    check("R3", "vsync period", per, 960);
    check("R5", "vsync width", wid, 160);

    wait_frame_start();
    cnt = 0;
    for (int i = 0; i < 960; i++) begin
      if (de_o) cnt++;
      @(negedge clk);
    end
    check("R8", "de cycles per frame", cnt, 384);

    // R13: mid-frame total change waits for the frame boundary
    wait_at(3, 0);
    wr(0, extent(11, 5));
    pulse(0, 0, per, wid);
    check("R13", "old line length kept", per, 80);
    wait_frame_start();
    wait_at(1, 0);
    pulse(0, 0, per, wid);
    check("R13", "new line length", per, 96);
    wr(0, extent(9, 5));
    wait_frame_start();

    // R13: write sampled on the very last pixel of the frame
    wait_at(11, 78);
    wr(1, syncw(6, 3, 0));
    pulse(0, 0, per, wid);
    check("R13", "width in frame after boundary write", wid, 16);
    wait_frame_start();
    pulse(0, 0, per, wid);
    check("R4", "width 3 chars", wid, 24);

    // R6: zero width gives no pulse
    wr(1, syncw(6, 0, 0));
    wait_frame_start();
    cnt = 0;
    for (int i = 0; i < 960; i++) begin
      if (hsync_o) cnt++;
      @(negedge clk);
    end
    check("R6", "hsync active cycles", cnt, 0);
    wr(1, syncw(6, 2, 0));

    // R7: active-low polarity
    wr(1, syncw(6, 2, 1));
    wr(3, syncw(8, 2, 1));
    hneg = 1; vneg = 1;
    wait_frame_start();
    check("R7", "hsync idle high", hsync_o, 1);
    pulse(0, hneg, per, wid);
    check("R7", "hsync low width", wid, 16);
    pulse(1, vneg, per, wid);
    check("R7", "vsync low width", wid, 160);
    wr(1, syncw(6, 2, 0));
    wr(3, syncw(8, 2, 0));
    hneg = 0; vneg = 0;
    wait_frame_start();

    // R11: composite sync
    wr(4, 32'hE);
    wait_at(9, 0);
    check("R11", "hsync pin inside vsync, outside hpulse", hsync_o, 1);
    wait_at(9, 56);
    check("R11", "hsync pin inside both pulses", hsync_o, 0);
    wr(4, 32'hC);

    // R12: interlace field flag
    wr(4, 32'hD);
    wait_frame_start();
    f0 = field_o;
    wait_frame_start();
    check("R12", "field toggled", field_o, !f0);
    wr(4, 32'hC);
    check("R12", "field cleared", field_o, 0);

    // R9: display off, counters still move
    wr(4, 32'h8);
    repeat (5) @(negedge clk);
    check("R9", "de_o off", de_o, 0);
    check("R9", "hblank_o off", hblank_o, 1);
    check("R9", "vblank_o off", vblank_o, 1);
    check("R9", "hsync idle", hsync_o, 0);
    px0 = pix_x;
    @(negedge clk);
    check("R9", "counting continues", pix_x != PW'(px0), 1);

    // R10: engine stopped
    wr(4, 32'h4);
    repeat (3) @(negedge clk);
    check("R10", "pix_x held", pix_x, 0);
    repeat (50) @(negedge clk);
    check("R10", "pix_x still held", pix_x, 0);
    check("R10", "line_y held", line_y, 0);

    finish_run();
  end

endmodule